// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Sequencer

This block is a four-stage twisted-ring counter. On every clock edge the register shifts by one stage. The first stage takes the inverse of the last stage. The register therefore walks through eight legal patterns and then repeats. Each legal pattern is recognised by a two-input AND of two stages. The result is presented as eight one-hot lines plus a 3-bit position index, so the block can serve directly as an eight-phase sequence generator.

The other eight patterns a 4-bit register can hold are not part of the cycle. A plain twisted ring that lands in one of them stays among them for good. To prevent this, the next-state equation of the third stage is modified so that every illegal pattern drains back into the legal cycle. A parameter removes the modification, which turns the block back into a plain twisted ring. A test-only load port writes any pattern into the register, so illegal patterns can be injected on purpose.

Top module: `johnson_seq`

## Requirements
- R1: After reset, with no load, successive clocks give stage vectors `ring[3:0]` of 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, and then the sequence repeats. Bit i is stage i, and stage 0 is the first stage.
- R2: A synchronous active-high `rst` sets every stage to 0 at the next edge. It takes precedence over `tst_load`.
- R3: With `rst` low and `tst_load` high, the next edge writes `tst_value` into the stages. Bit i of `tst_value` goes to stage i.
- R4: For the legal vector at position k of the R1 list (k = 0..7), `seq_hot` equals 1<<k. For any illegal vector, three or more lines of `seq_hot` are high.
- R5: In a legal state, `seq_idx` equals the position k of the current vector in the R1 list.
- R6: With `FIX_EN`=1, the register returns to a legal vector within 5 clocks from any of the eight illegal vectors.
- R7: With `FIX_EN`=0, an illegal vector is never followed by a legal one. The block then behaves as a plain twisted ring: stage 0 takes the inverse of stage 3, and each other stage takes its lower neighbour.
- R8: With `FIX_EN`=1, the legal cycle is identical to that of the plain ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tst_load | input | 1 | Test-only parallel write enable |
| tst_value | input | 4 | Stage vector written when `tst_load` is high |
| seq_hot | output | 8 | One-hot decode of the sequence position |
| seq_idx | output | 3 | Binary sequence position |

## Verification
The assertions assume that `rst` is high at time zero and on the first edge. They also assume that `tst_load` is a pulse, dropped once the injected pattern has been written. Only then does the recovery window count free-running cycles.

The stimulus holds reset for two edges. It then raises the load for exactly one cycle per injected vector, covering all sixteen vectors on a corrected instance and on an uncorrected instance that share the same inputs. After each injection it lets both instances run freely long enough for the corrected one to recover and for the uncorrected one to complete a full illegal loop.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int STAGES = 4;
    localparam int NSEQ   = 2 * STAGES;
    localparam int IDXW   = $clog2(NSEQ);

    typedef logic [STAGES-1:0] ring_t;
    typedef logic [NSEQ-1:0]   hot_t;
    typedef logic [IDXW-1:0]   idx_t;

    typedef struct packed {
        logic  en;
        ring_t val;
    } inject_t;

    // Legal pattern at position k: ones fill from stage 0, then drain from stage 0.
    function automatic ring_t seq_value(int k);
        ring_t ones;
        ones = '1;
        if (k <= STAGES)
            return ring_t'(ones >> (STAGES - k));
        return ring_t'(ones << (k - STAGES));
    endfunction

    function automatic logic is_legal(ring_t r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NSEQ; k++)
            if (r == seq_value(k)) hit = 1'b1;
        return hit;
    endfunction

    function automatic idx_t seq_pos(ring_t r);
        idx_t p;
        p = '0;
        for (int k = 0; k < NSEQ; k++)
            if (r == seq_value(k)) p = idx_t'(k);
        return p;
    endfunction

endpackage

// File: rtl/jc_ring.sv
module jc_ring
    import jc_pkg::*;
#(
    parameter bit FIX_EN = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  inject_t inj,
    output ring_t   ring
);

    localparam int MAX_BAD = 5;

    ring_t nxt;

    always_comb begin
        nxt[0] = ~ring[STAGES-1];
        for (int i = 1; i < STAGES; i++)
            nxt[i] = ring[i-1];
        if (FIX_EN)
            nxt[2] = (ring[0] | ring[2]) & ring[1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ring <= '0;
        else if (inj.en)
            ring <= inj.val;
        else
            ring <= nxt;
    end

    // Run length of illegal states since the last reset, load or legal state.
    logic [2:0] bad_run;
    always_ff @(posedge clk) begin
        if (rst || inj.en || is_legal(ring))
            bad_run <= '0;
        else if (bad_run != 3'd7)
            bad_run <= bad_run + 3'd1;
    end

    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (ring == '0));

    a_r3_load_writes: assert property (@(posedge clk) disable iff (rst)
        inj.en |=> (ring == $past(inj.val)));

    a_r1_legal_advance: assert property (@(posedge clk) disable iff (rst)
        (!inj.en && is_legal(ring)) |=>
            (ring == seq_value((int'($past(seq_pos(ring))) + 1) % NSEQ)));

    generate
        if (FIX_EN) begin : g_fix_chk
            a_r6_recover_bound: assert property (@(posedge clk) disable iff (rst)
                bad_run <= 3'(MAX_BAD));
        end else begin : g_raw_chk
            a_r7_stays_illegal: assert property (@(posedge clk) disable iff (rst)
                (!inj.en && !is_legal(ring)) |=> !is_legal(ring));
        end
    endgenerate

endmodule

// File: rtl/jc_decode.sv
module jc_decode
    import jc_pkg::*;
(
    input  ring_t ring,
    output hot_t  hot
);

    genvar k;
    generate
        for (k = 0; k < NSEQ; k++) begin : g_term
            if (k == 0) begin : g_head
                assign hot[k] = ~ring[0] & ~ring[STAGES-1];
            end else if (k < STAGES) begin : g_fill
                assign hot[k] = ring[k-1] & ~ring[k];
            end else if (k == STAGES) begin : g_full
                assign hot[k] = ring[0] & ring[STAGES-1];
            end else begin : g_drain
                assign hot[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown(ring)) begin
            if (is_legal(ring))
                a_r4_single_line: assert ($countones(hot) == 1);
            else
                a_r4_multi_line: assert ($countones(hot) >= 3);
        end
    end

endmodule

// File: rtl/jc_encode.sv
module jc_encode
    import jc_pkg::*;
(
    input  hot_t hot,
    output idx_t idx
);

    always_comb begin
        idx = '0;
        for (int k = 0; k < NSEQ; k++)
            if (hot[k]) idx = idx | idx_t'(k);
    end

endmodule

// File: rtl/johnson_seq.sv
module johnson_seq
    import jc_pkg::*;
#(
    parameter bit FIX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tst_load,
    input  logic [STAGES-1:0] tst_value,
    output logic [NSEQ-1:0]   seq_hot,
    output logic [IDXW-1:0]   seq_idx
);

    inject_t inj;
    ring_t   ring;

    assign inj.en  = tst_load;
    assign inj.val = tst_value;

    jc_ring #(.FIX_EN(FIX_EN)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .inj  (inj),
        .ring (ring)
    );

    jc_decode u_dec (
        .ring (ring),
        .hot  (seq_hot)
    );

    jc_encode u_enc (
        .hot (seq_hot),
        .idx (seq_idx)
    );

    a_r5_index_matches: assert property (@(posedge clk) disable iff (rst)
        ($countones(seq_hot) == 1) |-> (seq_hot[seq_idx] == 1'b1));

endmodule

// File: tb/test_johnson_seq.sv
`timescale 1ns/1ps
module test_johnson_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld  = 1'b0;
    logic [3:0] lv  = 4'h0;
    logic [7:0] fix_hot, raw_hot;
    logic [2:0] fix_idx, raw_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    johnson_seq #(.FIX_EN(1'b1)) i_johnson_seq (
        .clk(clk), .rst(rst), .tst_load(ld), .tst_value(lv),
        .seq_hot(fix_hot), .seq_idx(fix_idx));

    johnson_seq #(.FIX_EN(1'b0)) i_johnson_seq_raw (
        .clk(clk), .rst(rst), .tst_load(ld), .tst_value(lv),
        .seq_hot(raw_hot), .seq_idx(raw_idx));

    function automatic logic [3:0] m_vec(int k);
        return (k <= 4) ? 4'(4'hF >> (4 - k)) : 4'(4'hF << (k - 4));
    endfunction

    function automatic int m_pos(logic [3:0] r);
        int p = -1;
        for (int k = 0; k < 8; k++) if (m_vec(k) == r) p = k;
        return p;
    endfunction

    function automatic logic [3:0] m_step(logic [3:0] r, bit fix);
        logic [3:0] n;
        n = {r[2:0], ~r[3]};
        if (fix) n[2] = (r[0] | r[2]) & r[1];
        return n;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare one instance's outputs against the model vector.
    task automatic cmp(logic [3:0] m, logic [7:0] hot, logic [2:0] idx, string req);
        int p = m_pos(m);
        if (p >= 0) begin
            chk(hot == 8'(1 << p), {req, " R4 hot"}, hot, 1 << p);
            chk(int'(idx) == p, {req, " R5 idx"}, idx, p);
        end else begin
            chk($countones(hot) >= 3, {req, " R4 illegal lines"}, hot, 3);
        end
    endtask

    initial begin
        logic [3:0] mf, mr;
        @(negedge clk);
        tick;
        chk(fix_hot == 8'h01, "R2 reset hot", fix_hot, 1);
        chk(fix_idx == 3'd0, "R2 reset idx", fix_idx, 0);
        chk(raw_hot == 8'h01, "R2 reset raw", raw_hot, 1);
        rst = 1'b0;
        mf = 4'h0;
        for (int c = 0; c < 20; c++) begin
            tick;
            mf = m_step(mf, 1'b1);
            chk(m_pos(mf) == (c + 1) % 8, "R1 model order", m_pos(mf), (c + 1) % 8);
            cmp(mf, fix_hot, fix_idx, "R1 fixed");
            chk(raw_hot == fix_hot, "R8 raw matches", raw_hot, fix_hot);
        end
        // Reset wins over load.
        rst = 1'b1; ld = 1'b1; lv = 4'h5;
        tick;
        chk(fix_hot == 8'h01, "R2 precedence", fix_hot, 1);
        chk(raw_hot == 8'h01, "R2 precedence raw", raw_hot, 1);
        rst = 1'b0; ld = 1'b0;
        // Exhaustive injection of all sixteen vectors.
        for (int v = 0; v < 16; v++) begin
            int rec = -1;
            ld = 1'b1; lv = 4'(v);
            tick;
            ld = 1'b0;
            mf = 4'(v); mr = 4'(v);
            cmp(mf, fix_hot, fix_idx, "R3 load fixed");
            cmp(mr, raw_hot, raw_idx, "R3 load raw");
            if (m_pos(mf) >= 0) rec = 0;
            for (int c = 1; c <= 10; c++) begin
                tick;
                mf = m_step(mf, 1'b1);
                mr = m_step(mr, 1'b0);
                cmp(mf, fix_hot, fix_idx, "R6 fixed run");
                cmp(mr, raw_hot, raw_idx, "R7 raw run");
                if (rec < 0 && $countones(fix_hot) == 1) rec = c;
                if (m_pos(4'(v)) < 0)
                    chk($countones(raw_hot) >= 3, "R7 stays illegal", raw_hot, 3);
            end
            chk(rec >= 0 && rec <= 5, "R6 recovery clocks", rec, 5);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule